// File: doc/BRIEF.md
# Destination Address Filter

This block decides, one destination address at a time, whether an incoming Ethernet frame should be kept. The receive path hands it the six address bytes together with a one-cycle strobe. A fixed number of cycles later the block returns a one-cycle result strobe and an accept flag. The flag holds its value until the next result.

The decision draws on four sources. The first is an exact compare against a station address held in two configuration words. The second is the broadcast address, which a reject control can suppress. The third is multicast, matched through a 64-entry hash table that is indexed by six bits of the address CRC-32. The fourth is a promiscuous override that accepts every frame.

The CRC stage can be given its own pipeline register, which trades one cycle of latency for a shorter path. Configuration inputs are sampled when the decision is made, so they must be held steady from the address strobe until the result strobe.

Top module: `da_filter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `out_valid` and `out_accept` are both 0.
- R2: Each `in_valid` pulse produces exactly one `out_valid` pulse, LATENCY cycles later. LATENCY is 1 + PIPE_CRC, which is 2 by default. `out_valid` is 0 in every other cycle.
- R3: `out_accept` changes only in a cycle where `out_valid` is 1, and otherwise keeps the last result.
- R4: An address equal to the station address is accepted. `in_addr` carries address byte k (byte 0 is sent first) in bits 8k+7:8k. Station byte 0 is `sta_hi[15:8]` and byte 1 is `sta_hi[7:0]`. Bytes 2, 3, 4 and 5 are `sta_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R5: A unicast address (`in_addr[0]` = 0) that differs from the station address is rejected when `promisc` is 0.
- R6: The all-ones address is accepted when `rej_bcast` is 0.
- R7: The all-ones address is rejected when `rej_bcast` is 1, unless `promisc` is 1 or it equals the station address.
- R8: A multicast address (`in_addr[0]` = 1, and not all ones) is accepted exactly when the hash bit it selects is 1. To find that bit, compute a CRC-32 over bytes 0 to 5. Each byte is taken least significant bit first, with polynomial 0x04C11DB7, an initial value of all ones and no final inversion. The index is CRC bits 31:26. Index bit 5 picks `hash_hi` (1) or `hash_lo` (0), and index bits 4:0 pick the bit within that word.
- R9: With both hash words all ones, every multicast address is accepted.
- R10: With `promisc` = 1, every address is accepted.
- R11: The all-ones address is never treated as multicast. With `rej_bcast` = 1 and both hash words all ones, it is still rejected.
- R12: Strobes on consecutive cycles each get their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address strobe |
| in_addr | input | 48 | Destination address, byte k in bits 8k+7:8k |
| sta_lo | input | 32 | Station address bytes 2..5 |
| sta_hi | input | 16 | Station address bytes 0..1 |
| hash_lo | input | 32 | Multicast hash bits 0..31 |
| hash_hi | input | 32 | Multicast hash bits 32..63 |
| rej_bcast | input | 1 | Reject broadcast frames |
| promisc | input | 1 | Accept every frame |
| out_valid | output | 1 | Result strobe |
| out_accept | output | 1 | Accept decision, held until next result |

## Verification
The bound checker checks three things on every cycle: the result timing, that the accept flag is held between results, and the address-level outcomes that need no CRC. Those outcomes are the promiscuous override, broadcast accepted or rejected, and unicast mismatch. The multicast hash lookup depends on a CRC-32 over the address, so only the bench scenarios cover it. The bench computes the index itself, sets exactly that bit, all bits except that bit, or all ones, and checks the outcome. The bench scenarios also cover the station byte order and the back-to-back ordering of results.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

   localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
   localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

   typedef struct packed {
      logic       bcast;
      logic       mcast;
      logic       sta_hit;
      logic [5:0] idx;
   } addr_class_t;

   // Serial CRC-32, bits taken in wire order (byte 0 first, LSB first).
   function automatic logic [31:0] addr_crc(input logic [47:0] a);
      logic [31:0] c;
      logic        fb;
      c = CRC_SEED;
      for (int i = 0; i < 48; i++) begin
         fb = c[31] ^ a[i];
         c  = {c[30:0], 1'b0};
         if (fb) c = c ^ CRC_POLY;
      end
      return c;
   endfunction

endpackage

// File: rtl/dafilt_hash_index.sv
module dafilt_hash_index #(
   parameter int ADDR_W = 48,
   parameter int IDX_W  = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);
   import dafilt_pkg::*;

   logic [31:0] crc;

   always_comb begin
      crc = addr_crc(addr);
      idx = crc[31 -: IDX_W];
   end
endmodule

// File: rtl/dafilt_classify.sv
module dafilt_classify #(
   parameter int ADDR_W = 48,
   parameter int STA_LO_W = 32,
   parameter int STA_HI_W = 16
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic [STA_LO_W-1:0] sta_lo,
   input  logic [STA_HI_W-1:0] sta_hi,
   output logic                bcast,
   output logic                mcast,
   output logic                sta_hit
);
   localparam int NBYTES = ADDR_W / 8;
   localparam int LO_BYTES = STA_LO_W / 8;
   localparam int HI_BYTES = STA_HI_W / 8;

   logic [ADDR_W-1:0] station;

   // Byte k of the station lives at addr bits 8k+7:8k; high word holds
   // bytes 0.. most significant first, low word the rest likewise.
   for (genvar k = 0; k < NBYTES; k++) begin : g_sta
      if (k < HI_BYTES) begin : g_hi
         assign station[8*k +: 8] = sta_hi[8*(HI_BYTES-1-k) +: 8];
      end else begin : g_lo
         assign station[8*k +: 8] = sta_lo[8*(LO_BYTES-1-(k-HI_BYTES)) +: 8];
      end
   end

   always_comb begin
      bcast   = &addr;
      mcast   = addr[0] & ~bcast;
      sta_hit = (addr == station);
   end
endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide #(
   parameter int HASH_REG_W = 32,
   parameter int IDX_W      = 6
) (
   input  dafilt_pkg::addr_class_t cls,
   input  logic [HASH_REG_W-1:0]   hash_lo,
   input  logic [HASH_REG_W-1:0]   hash_hi,
   input  logic                    rej_bcast,
   input  logic                    promisc,
   output logic                    accept
);
   logic [HASH_REG_W-1:0] word;
   logic                  hbit;

   always_comb begin
      word   = cls.idx[IDX_W-1] ? hash_hi : hash_lo;
      hbit   = word[cls.idx[IDX_W-2:0]];
      accept = promisc
             | cls.sta_hit
             | (cls.bcast & ~rej_bcast)
             | (cls.mcast & hbit);
   end
endmodule

// File: rtl/da_filter.sv
module da_filter #(
   parameter int ADDR_W     = 48,
   parameter int HASH_REG_W = 32,
   parameter int PIPE_CRC   = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [ADDR_W-1:0]     in_addr,
   input  logic [31:0]           sta_lo,
   input  logic [15:0]           sta_hi,
   input  logic [HASH_REG_W-1:0] hash_lo,
   input  logic [HASH_REG_W-1:0] hash_hi,
   input  logic                  rej_bcast,
   input  logic                  promisc,
   output logic                  out_valid,
   output logic                  out_accept
);
   import dafilt_pkg::*;

   localparam int HASH_SIZE = 2 * HASH_REG_W;
   localparam int IDX_W     = $clog2(HASH_SIZE);
   localparam int LATENCY   = 1 + PIPE_CRC;

   if (ADDR_W != 48) begin : g_bad_addr
      $error("da_filter: ADDR_W must be 48");
   end
   if (HASH_SIZE != 64) begin : g_bad_hash
      $error("da_filter: hash table must have 64 entries");
   end
   if (PIPE_CRC != 0 && PIPE_CRC != 1) begin : g_bad_pipe
      $error("da_filter: PIPE_CRC must be 0 or 1");
   end

   addr_class_t cls_c, cls_s;
   logic        vld_s;
   logic        acc_c;

   dafilt_hash_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_idx (
      .addr (in_addr),
      .idx  (cls_c.idx)
   );

   dafilt_classify #(.ADDR_W(ADDR_W), .STA_LO_W(32), .STA_HI_W(16)) u_cls (
      .addr    (in_addr),
      .sta_lo  (sta_lo),
      .sta_hi  (sta_hi),
      .bcast   (cls_c.bcast),
      .mcast   (cls_c.mcast),
      .sta_hit (cls_c.sta_hit)
   );

   if (PIPE_CRC == 1) begin : g_pipe
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_s <= 1'b0;
            cls_s <= '0;
         end else begin
            vld_s <= in_valid;
            if (in_valid) cls_s <= cls_c;
         end
      end
   end else begin : g_flat
      assign vld_s = in_valid;
      assign cls_s = cls_c;
   end

   dafilt_decide #(.HASH_REG_W(HASH_REG_W), .IDX_W(IDX_W)) u_dec (
      .cls       (cls_s),
      .hash_lo   (hash_lo),
      .hash_hi   (hash_hi),
      .rej_bcast (rej_bcast),
      .promisc   (promisc),
      .accept    (acc_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_accept <= 1'b0;
      end else begin
         out_valid <= vld_s;
         if (vld_s) out_accept <= acc_c;
      end
   end
endmodule

// File: rtl/da_filter_chk.sv
module da_filter_chk #(
   parameter int LAT = 2
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [47:0] in_addr,
   input logic [31:0] sta_lo,
   input logic [15:0] sta_hi,
   input logic        rej_bcast,
   input logic        promisc,
   input logic        out_valid,
   input logic        out_accept
);
   logic [47:0] sta_full;
   assign sta_full = {sta_lo[7:0], sta_lo[15:8], sta_lo[23:16], sta_lo[31:24],
                      sta_hi[7:0], sta_hi[15:8]};

   // R2
   result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, LAT));

   // R3
   accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_accept) |-> out_valid);

   // R10
   promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && promisc && $stable(promisc) |-> out_accept);

   // R6
   bcast_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_valid && (&in_addr) && !rej_bcast, LAT) |-> out_accept);

   // R7
   bcast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_valid && (&in_addr) && rej_bcast && !promisc
                         && (sta_full != in_addr), LAT) |-> !out_accept);

   // R5
   ucast_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_valid && !in_addr[0] && !promisc
                         && (sta_full != in_addr), LAT) |-> !out_accept);
endmodule

bind da_filter da_filter_chk #(.LAT(LATENCY)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_addr    (in_addr),
   .sta_lo     (sta_lo),
   .sta_hi     (sta_hi),
   .rej_bcast  (rej_bcast),
   .promisc    (promisc),
   .out_valid  (out_valid),
   .out_accept (out_accept)
);

// File: tb/tb_da_filter.sv
module tb_da_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [47:0] in_addr = '0;
   logic [31:0] sta_lo = '0;
   logic [15:0] sta_hi = '0;
   logic [31:0] hash_lo = '0;
   logic [31:0] hash_hi = '0;
   logic        rej_bcast = 1'b0;
   logic        promisc = 1'b0;
   logic        out_valid;
   logic        out_accept;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   da_filter dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .sta_lo(sta_lo), .sta_hi(sta_hi), .hash_lo(hash_lo), .hash_hi(hash_hi),
      .rej_bcast(rej_bcast), .promisc(promisc),
      .out_valid(out_valid), .out_accept(out_accept)
   );

   // Independent reference for the hash index (R8).
   function automatic logic [5:0] ref_idx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      logic fb;
      for (int i = 0; i < 48; i++) begin
         fb = c[31] ^ a[i];
         c = c << 1;
         if (fb) c = c ^ 32'h04C1_1DB7;
      end
      return c[31:26];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Vector: addr | sta_lo | sta_hi | rej | pro | hash mode | expected
   // hash mode: 0 none, 1 all ones, 2 only the selected bit, 3 all but it
   localparam int NV = 12;
   localparam logic [100:0] VEC [NV] = '{
      {48'h5544_3322_1102, 32'h2233_4455, 16'h0211, 1'b0, 1'b0, 2'd0, 1'b1}, // R4 station hit
      {48'h5544_3322_1104, 32'h2233_4455, 16'h0211, 1'b0, 1'b0, 2'd1, 1'b0}, // R5 unicast miss
      {48'h5544_3322_1104, 32'h2233_4455, 16'h0211, 1'b0, 1'b1, 2'd0, 1'b1}, // R10 promisc
      {48'hFFFF_FFFF_FFFF, 32'h2233_4455, 16'h0211, 1'b0, 1'b0, 2'd0, 1'b1}, // R6 bcast pass
      {48'hFFFF_FFFF_FFFF, 32'h2233_4455, 16'h0211, 1'b1, 1'b0, 2'd1, 1'b0}, // R7 R11 bcast block
      {48'hFFFF_FFFF_FFFF, 32'h2233_4455, 16'h0211, 1'b1, 1'b1, 2'd0, 1'b1}, // R10 promisc bcast
      {48'h0100_5E00_0001, 32'h2233_4455, 16'h0211, 1'b0, 1'b0, 2'd0, 1'b0}, // R8 empty table
      {48'h0100_5E00_0001, 32'h2233_4455, 16'h0211, 1'b0, 1'b0, 2'd2, 1'b1}, // R8 bit set
      {48'h0100_5E00_0001, 32'h2233_4455, 16'h0211, 1'b0, 1'b0, 2'd3, 1'b0}, // R8 other bits
      {48'h6677_8899_AA33, 32'h2233_4455, 16'h0211, 1'b0, 1'b0, 2'd1, 1'b1}, // R9 all ones
      {48'h1412_100E_0C0A, 32'h0E10_1214, 16'h0A0C, 1'b0, 1'b0, 2'd0, 1'b1}, // R4 byte order
      {48'h0A0C_0E10_1214, 32'h0E10_1214, 16'h0A0C, 1'b0, 1'b0, 2'd0, 1'b0}  // R4 reversed
   };

   task automatic apply_hash(input logic [47:0] a, input logic [1:0] hm);
      logic [63:0] h;
      logic [5:0]  ix = ref_idx(a);
      case (hm)
         2'd0: h = '0;
         2'd1: h = '1;
         2'd2: begin h = '0; h[ix] = 1'b1; end
         default: begin h = '1; h[ix] = 1'b0; end
      endcase
      hash_lo = h[31:0];
      hash_hi = h[63:32];
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 during reset
      check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      check(out_accept == 1'b0, "R1", "out_accept in reset", out_accept, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 after release
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(out_accept == 1'b0, "R1", "out_accept after reset", out_accept, 0);

      for (int v = 0; v < NV; v++) begin
         logic [47:0] a;
         logic        ex;
         a = VEC[v][100:53];
         ex = VEC[v][0];
         sta_lo = VEC[v][52:21];
         sta_hi = VEC[v][20:5];
         rej_bcast = VEC[v][4];
         promisc = VEC[v][3];
         apply_hash(a, VEC[v][2:1]);
         in_addr = a;
         in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         // R2 not yet
         check(out_valid == 1'b0, "R2", $sformatf("early valid v%0d", v), out_valid, 0);
         @(negedge clk);
         check(out_valid == 1'b1, "R2", $sformatf("valid v%0d", v), out_valid, 1);
         check(out_accept == ex, "R4-R11 table", $sformatf("accept v%0d", v), out_accept, ex);
         in_addr = ~a;
         @(negedge clk);
         // R3 held
         check(out_valid == 1'b0, "R2", $sformatf("single pulse v%0d", v), out_valid, 0);
         check(out_accept == ex, "R3", $sformatf("hold v%0d", v), out_accept, ex);
      end

      // R12 back-to-back: station hit then unicast miss
      sta_lo = 32'h2233_4455; sta_hi = 16'h0211;
      rej_bcast = 1'b0; promisc = 1'b0; hash_lo = '0; hash_hi = '0;
      in_valid = 1'b1; in_addr = 48'h5544_3322_1102;
      @(negedge clk);
      in_addr = 48'h5544_3322_1106;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, "R12", "first valid", out_valid, 1);
      check(out_accept == 1'b1, "R12", "first accept", out_accept, 1);
      @(negedge clk);
      check(out_valid == 1'b1, "R12", "second valid", out_valid, 1);
      check(out_accept == 1'b0, "R12", "second accept", out_accept, 0);
      @(negedge clk);
      check(out_valid == 1'b0, "R12", "idle after pair", out_valid, 0);

      // R3: config change with no strobe leaves accept alone
      promisc = 1'b1;
      repeat (3) @(negedge clk);
      check(out_accept == 1'b0, "R3", "no strobe, promisc set", out_accept, 0);

      done = 1'b1;
      finish_run();
   end
endmodule